// File: doc/BRIEF.md
# Flash Command and Status Unit

This block is the device-side command interface of a block-erasable memory. Byte writes arrive on a command bus together with a block address. They are decoded into five operations: return reads to the array, switch reads to status, clear the error flags, arm an erase, and confirm that erase. An 8-bit status register reports readiness and the error conditions. The erase itself is modelled as a busy period of a fixed, parameterised number of cycles.

Per-block lock bits, a lock override input and a programming-voltage-ok input are checked when an erase is confirmed. Any failure sets the matching error flags in the status register. The error flags are sticky. They accumulate over any number of erases and are cleared only by an explicit clear command, so firmware may run a batch of erases and check the full status once at the end. A fault-injection input lets a bench force an erase to end in failure.

Top module: `flash_cmd_unit`

## Requirements
- R1: After reset, status_o is 8'h80 (ready, no errors) and stat_mode_o is 0, meaning reads return the array.
- R2: The write 8'h20 with block address B, followed by the write 8'hD0 with the same address B, starts an erase when the voltage is good and B is not protected. status_o[7] reads 0 from the confirming edge for exactly ERASE_CYCLES cycles and then returns to 1. erase_blk_o shows B.
- R3: After 8'h20, any next write other than 8'hD0 to the same block sets status_o[5] and status_o[4] together. This includes 8'h50 and 8'hD0 to a different block. No erase starts, and the unit goes back to idle.
- R4: If vpp_ok_i is low at the confirming write, status_o[3] is set and no erase starts.
- R5: If the lock bit of the block is set at confirm and unlock_ovr_i is low, status_o[1] and status_o[5] are set and no erase starts. If unlock_ovr_i is high, the erase proceeds normally.
- R6: Status bits 5, 4, 3 and 1 stay set through later commands and later successful erases. Only 8'h50 written while idle clears them.
- R7: In idle, 8'hFF clears stat_mode_o. 8'h70 and 8'h20 set it.
- R8: While busy, stat_mode_o is 1 and every command write is ignored. After the erase ends, stat_mode_o stays 1.
- R9: If fail_inject_i is high on the final cycle of an erase, status_o[5] is set when the unit becomes ready.
- R10: In idle, a code other than 8'hFF, 8'h70, 8'h50 or 8'h20 changes neither status_o nor stat_mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command write strobe, one cycle per write |
| cmd_data_i | input | 8 | Command code |
| cmd_blk_i | input | BLK_W | Block address accompanying the command |
| lock_bits_i | input | NUM_BLOCKS | Per-block protection bits |
| unlock_ovr_i | input | 1 | Overrides the protection bits when high |
| vpp_ok_i | input | 1 | Programming voltage within range |
| fail_inject_i | input | 1 | Forces the running erase to end in failure |
| status_o | output | 8 | Status: [7] ready, [5] erase error, [4] sequence error, [3] voltage error, [1] protect error, others 0 |
| stat_mode_o | output | 1 | 1 when reads return status, 0 when they return the array |
| erase_blk_o | output | BLK_W | Block recorded by the last erase setup |

## Verification
Every command takes effect at the clock edge that samples its write. Status, mode and the recorded block are therefore due one cycle after the strobe is driven. The bench drives on the falling edge and samples on the next falling edge. The busy flag is checked right after the confirm, again after ERASE_CYCLES-1 further cycles where it must still be low, and once more one cycle later where it must be high. A write slipped into the busy window is counted in that window, so the ignore check for busy does not shift the expected end. The sweeps cover every idle code, every code following setup, every block, and all lock, override and voltage cases.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_CLEAR      = 8'h50;
  localparam logic [7:0] OP_SETUP      = 8'h20;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;

  typedef enum logic {ST_IDLE, ST_SETUP} dec_st_e;

  typedef struct packed {
    logic start;
    logic seq_err;
    logic vpp_err;
    logic lock_err;
    logic clr;
  } evt_t;
endpackage

// File: rtl/fcu_decode.sv
module fcu_decode import fcu_pkg::*; #(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_we_i,
  input  logic [7:0]            cmd_data_i,
  input  logic [BLK_W-1:0]      cmd_blk_i,
  input  logic [NUM_BLOCKS-1:0] lock_bits_i,
  input  logic                  unlock_ovr_i,
  input  logic                  vpp_ok_i,
  input  logic                  busy_i,
  output evt_t                  evt_o,
  output logic                  mode_o,
  output logic [BLK_W-1:0]      blk_o
);
  dec_st_e          st_q, st_d;
  logic             mode_d;
  logic [BLK_W-1:0] blk_d;
  logic             acc;

  assign acc = cmd_we_i & ~busy_i;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_o;
    blk_d  = blk_o;
    evt_o  = '0;
    if (acc) begin
      if (st_q == ST_SETUP) begin
        st_d = ST_IDLE;
        if (cmd_data_i == OP_CONFIRM && cmd_blk_i == blk_o) begin
          if (!vpp_ok_i)                               evt_o.vpp_err  = 1'b1;
          else if (lock_bits_i[blk_o] && !unlock_ovr_i) evt_o.lock_err = 1'b1;
          else                                          evt_o.start    = 1'b1;
        end else begin
          evt_o.seq_err = 1'b1;
        end
      end else begin
        unique case (cmd_data_i)
          OP_READ_ARRAY: mode_d = 1'b0;
          OP_READ_STAT:  mode_d = 1'b1;
          OP_CLEAR:      evt_o.clr = 1'b1;
          OP_SETUP: begin
            st_d   = ST_SETUP;
            blk_d  = cmd_blk_i;
            mode_d = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_o <= 1'b0;
      blk_o  <= '0;
    end else begin
      st_q   <= st_d;
      mode_o <= mode_d;
      blk_o  <= blk_d;
    end
  end
endmodule

// File: rtl/fcu_timer.sv
module fcu_timer #(
  parameter int ERASE_CYCLES = 16,
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_W'(ERASE_CYCLES - 1);
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fcu_status.sv
module fcu_status import fcu_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  evt_t evt_i,
  input  logic done_i,
  input  logic fail_i,
  input  logic busy_i,
  output logic [7:0] status_o
);
  logic erase_err_q, seq_err_q, vpp_err_q, prot_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_err_q <= 1'b0;
      seq_err_q   <= 1'b0;
      vpp_err_q   <= 1'b0;
      prot_err_q  <= 1'b0;
    end else if (evt_i.clr) begin
      erase_err_q <= 1'b0;
      seq_err_q   <= 1'b0;
      vpp_err_q   <= 1'b0;
      prot_err_q  <= 1'b0;
    end else begin
      if (evt_i.seq_err || evt_i.lock_err || (done_i && fail_i)) erase_err_q <= 1'b1;
      if (evt_i.seq_err)  seq_err_q  <= 1'b1;
      if (evt_i.vpp_err)  vpp_err_q  <= 1'b1;
      if (evt_i.lock_err) prot_err_q <= 1'b1;
    end
  end

  assign status_o = {~busy_i, 1'b0, erase_err_q, seq_err_q, vpp_err_q, 1'b0, prot_err_q, 1'b0};
endmodule

// File: rtl/flash_cmd_unit.sv
module flash_cmd_unit import fcu_pkg::*; #(
  parameter int NUM_BLOCKS   = 8,
  parameter int ERASE_CYCLES = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_we_i,
  input  logic [7:0]            cmd_data_i,
  input  logic [BLK_W-1:0]      cmd_blk_i,
  input  logic [NUM_BLOCKS-1:0] lock_bits_i,
  input  logic                  unlock_ovr_i,
  input  logic                  vpp_ok_i,
  input  logic                  fail_inject_i,
  output logic [7:0]            status_o,
  output logic                  stat_mode_o,
  output logic [BLK_W-1:0]      erase_blk_o
);
  evt_t evt;
  logic busy, done, mode;

  fcu_decode #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_decode (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_data_i, .cmd_blk_i, .lock_bits_i,
    .unlock_ovr_i, .vpp_ok_i,
    .busy_i (busy),
    .evt_o  (evt),
    .mode_o (mode),
    .blk_o  (erase_blk_o)
  );

  fcu_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i (evt.start),
    .busy_o  (busy),
    .done_o  (done)
  );

  fcu_status u_status (
    .clk_i, .rst_ni,
    .evt_i    (evt),
    .done_i   (done),
    .fail_i   (fail_inject_i),
    .busy_i   (busy),
    .status_o (status_o)
  );

  assign stat_mode_o = mode | busy;
endmodule

// File: rtl/fcu_checker.sv
module fcu_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [7:0] cmd_data_i,
  input logic [7:0] status_o,
  input logic       stat_mode_o
);
  localparam logic [7:0] STICKY = 8'h3A;

  p_busy_from_confirm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[7]) |-> ($past(cmd_we_i) && $past(cmd_data_i) == 8'hD0));

  p_seq_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] |-> status_o[5]);

  p_protect_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> status_o[5]);

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_we_i && cmd_data_i == 8'h50) |=>
      ((status_o & $past(status_o) & STICKY) == ($past(status_o) & STICKY)));

  p_busy_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[7] |-> stat_mode_o);
endmodule

bind flash_cmd_unit fcu_checker u_fcu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_we_i    (cmd_we_i),
  .cmd_data_i  (cmd_data_i),
  .status_o    (status_o),
  .stat_mode_o (stat_mode_o)
);

// File: tb/tb_flash_cmd_unit.sv
`timescale 1ns/1ps
module tb_flash_cmd_unit;
  localparam int NB = 8;
  localparam int EC = 16;
  localparam int BW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_we_i = 1'b0;
  logic [7:0]    cmd_data_i = '0;
  logic [BW-1:0] cmd_blk_i = '0;
  logic [NB-1:0] lock_bits_i = '0;
  logic          unlock_ovr_i = 1'b0;
  logic          vpp_ok_i = 1'b1;
  logic          fail_inject_i = 1'b0;
  logic [7:0]    status_o;
  logic          stat_mode_o;
  logic [BW-1:0] erase_blk_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  flash_cmd_unit #(.NUM_BLOCKS(NB), .ERASE_CYCLES(EC)) dut (.*);

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] code, input logic [BW-1:0] blk);
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_data_i = code; cmd_blk_i = blk;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
  endtask

  // good erase of blk; expects final status exp_end
  task automatic erase_ok(input logic [BW-1:0] blk, input logic [7:0] exp_end, input string req);
    wr(8'h20, blk);
    wr(8'hD0, blk);
    chk(status_o[7], 0, {req, " busy at confirm"});
    chk(erase_blk_o, blk, {req, " erase block"});
    wr(8'hFF, blk);  // R8: ignored while busy
    chk(stat_mode_o, 1, "R8 mode while busy");
    repeat (EC - 3) @(negedge clk_i);
    chk(status_o[7], 0, {req, " busy last cycle"});
    @(negedge clk_i);
    chk(status_o, exp_end, {req, " ready status"});
    chk(stat_mode_o, 1, "R8 mode after erase");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(status_o, 8'h80, "R1 status");
    chk(stat_mode_o, 0, "R1 mode");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10: idle codes without effect
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hFF || c == 8'h70 || c == 8'h50 || c == 8'h20) continue;
      wr(8'(c), '0);
      chk(status_o, 8'h80, "R10 status");
      chk(stat_mode_o, 0, "R10 mode");
    end

    // R7: read mode switching
    wr(8'h70, '0); chk(stat_mode_o, 1, "R7 read-status");
    wr(8'hFF, '0); chk(stat_mode_o, 0, "R7 read-array");

    // R2 and R8 per block
    for (int b = 0; b < NB; b++) erase_ok(BW'(b), 8'h80, "R2");
    wr(8'hFF, '0); chk(stat_mode_o, 0, "R7 array after erase");
    wr(8'h20, 3'd5); chk(stat_mode_o, 1, "R7 setup selects status");
    wr(8'hFF, 3'd5); chk(status_o, 8'hB0, "R3 FF after setup");
    wr(8'h50, '0);

    // R9 then R6 sticky across good erase
    fail_inject_i = 1'b1;
    erase_ok(3'd2, 8'hA0, "R9");
    fail_inject_i = 1'b0;
    erase_ok(3'd4, 8'hA0, "R6 fail bit sticky");
    wr(8'h70, '0); chk(status_o, 8'hA0, "R6 survives read-status");
    wr(8'h50, '0); chk(status_o, 8'h80, "R6 clear");

    // R3: every non-confirm code after setup
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hD0) continue;
      wr(8'h20, 3'd1);
      wr(8'(c), 3'd1);
      chk(status_o, 8'hB0, "R3 seq error");
      wr(8'h50, '0);
      chk(status_o, 8'h80, "R6 clear after seq");
    end
    wr(8'h20, 3'd1); wr(8'hD0, 3'd6);
    chk(status_o, 8'hB0, "R3 confirm wrong block");
    wr(8'h50, '0);

    // R4: voltage error, sticky across good erase
    vpp_ok_i = 1'b0;
    wr(8'h20, 3'd3); wr(8'hD0, 3'd3);
    chk(status_o, 8'h88, "R4 vpp error no busy");
    vpp_ok_i = 1'b1;
    erase_ok(3'd3, 8'h88, "R6 vpp bit sticky");
    wr(8'h50, '0); chk(status_o, 8'h80, "R6 clear vpp");

    // R5: lock sweep
    for (int b = 0; b < NB; b++) begin
      lock_bits_i = NB'(1) << b;
      unlock_ovr_i = 1'b0;
      wr(8'h20, BW'(b)); wr(8'hD0, BW'(b));
      chk(status_o, 8'hA2, "R5 locked");
      wr(8'h50, '0);
      unlock_ovr_i = 1'b1;
      erase_ok(BW'(b), 8'h80, "R5 override");
      unlock_ovr_i = 1'b0;
      erase_ok(BW'((b + 1) % NB), 8'h80, "R5 other block unlocked");
    end
    lock_bits_i = '0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule